// File: doc/BRIEF.md
# Two-Bank Data Memory Address Decoder

This block is the data-memory front end of a small 8-bit microcontroller core. Each cycle it receives the 7-bit operand address from the current instruction and builds an 8-bit effective address. For a direct access it places the bank-select bit from the status register above the operand. When the operand names the virtual slot 00h, it uses the contents of the pointer register as the effective address instead. The effective address is then decoded into one of four destinations: a small set of core registers, 68 bytes of general-purpose RAM, an external peripheral-register port, or a hole that reads as zero.

Core registers and RAM appear at the same places in both banks, so code can reach them without switching banks. Peripheral slots are passed to the port with the full 8-bit address, which lets peripheral logic tell its bank-0 registers from its bank-1 registers. Reads are combinational. Writes commit on the rising clock edge.

Top module: `rfd_bank_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, the status, pointer and interrupt-control registers become 00h. The bank-select bit (status bit 5) is therefore 0 after reset.
- R2: When `opnd` is not 00h, the effective address is {status bit 5, `opnd`}. Bank 0 spans 00h–7Fh and bank 1 spans 80h–FFh.
- R3: When `opnd` is 00h, the 8-bit pointer register value is the effective address, for both reads and writes. The slot has no storage of its own.
- R4: An access through the pointer reaches bank-1 addresses even while status bit 5 is 0.
- R5: The core registers sit at these low-7-bit slots: program-counter low 02h, status 03h, pointer 04h, program-counter latch 0Ah, interrupt control 0Bh. Each one answers identically at its address plus 80h.
- R6: General-purpose RAM occupies 0Ch–4Fh. Address X and X+80h reach the same byte.
- R7: Slots 07h/87h, 50h–7Fh and D0h–FFh read 00h. Writes to them change no storage and do not assert `per_sel` or `per_we`.
- R8: An access through a pointer holding 00h or 80h reads 00h. A write through such a pointer is discarded.
- R9: Slots 01h, 05h, 06h, 08h and 09h, and their bank-1 images, assert `per_sel` and drive `per_addr` with the full effective address. A read returns `per_rdata`. `per_we` equals `wr_en` and `per_wdata` equals `wr_data`.
- R10: Reads follow the address with no clock. A write is visible only after the rising edge at which `wr_en` is high. Registers hold their value when `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd | input | 7 | Operand address from the instruction |
| wr_en | input | 1 | Write strobe for the addressed location |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data from the addressed location |
| per_sel | output | 1 | Effective address is a peripheral slot |
| per_addr | output | 8 | Full effective address forwarded to peripherals |
| per_we | output | 1 | Peripheral write strobe |
| per_wdata | output | 8 | Peripheral write data |
| per_rdata | input | 8 | Read data returned by the peripheral |
| pc_low | output | 8 | Program-counter low register |
| pc_latch | output | 8 | Program-counter high latch register |
| status_q | output | 8 | Status register (bit 5 selects the bank) |
| ptr_q | output | 8 | Pointer register |
| irq_ctrl_q | output | 8 | Interrupt-control register |

## Verification
Several properties are checked on every cycle against the block's internal effective address. They cover how that address is formed in both modes, zero reads from holes and null pointers, the routing of peripheral slots and their data, and register hold when no write occurs. The bench scenarios cover what needs a stored value to be seen again later: that a byte written in one bank reads back from the other, that core registers alias, that a pointer into bank 1 works while bank 0 is selected, and that writes to holes and null pointers leave RAM and registers untouched.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

    localparam int DW        = 8;
    localparam int OW        = 7;
    localparam int AW        = OW + 1;
    localparam int BANK_BIT  = 5;
    localparam int NCORE     = 5;

    localparam logic [OW-1:0] GPR_FIRST = 7'h0C;
    localparam logic [OW-1:0] GPR_LAST  = 7'h4F;
    localparam int GPR_DEPTH = int'(GPR_LAST) - int'(GPR_FIRST) + 1;

    typedef enum logic [1:0] {
        RG_HOLE,
        RG_CORE,
        RG_GPR,
        RG_PERIPH
    } rgn_e;

    typedef enum logic [2:0] {
        CR_PCL    = 3'd0,
        CR_STAT   = 3'd1,
        CR_PTR    = 3'd2,
        CR_PCLATH = 3'd3,
        CR_INTCON = 3'd4
    } core_e;

    // reset only status, pointer and interrupt control
    localparam logic [NCORE-1:0] CORE_RST_MASK = 5'b10110;

    typedef struct packed {
        rgn_e          rgn;
        core_e         core;
        logic [OW-1:0] gpr_idx;
    } dec_t;

    function automatic logic [AW-1:0] form_addr(input logic bank,
                                                input logic [OW-1:0] op,
                                                input logic [AW-1:0] ptr);
        if (op == '0) return ptr;
        return {bank, op};
    endfunction

    function automatic dec_t decode_slot(input logic [OW-1:0] slot);
        dec_t d;
        d.rgn     = RG_HOLE;
        d.core    = CR_PCL;
        d.gpr_idx = '0;
        case (slot)
            7'h02: begin d.rgn = RG_CORE; d.core = CR_PCL;    end
            7'h03: begin d.rgn = RG_CORE; d.core = CR_STAT;   end
            7'h04: begin d.rgn = RG_CORE; d.core = CR_PTR;    end
            7'h0A: begin d.rgn = RG_CORE; d.core = CR_PCLATH; end
            7'h0B: begin d.rgn = RG_CORE; d.core = CR_INTCON; end
            7'h01, 7'h05, 7'h06, 7'h08, 7'h09: d.rgn = RG_PERIPH;
            default: begin
                if (slot >= GPR_FIRST && slot <= GPR_LAST) begin
                    d.rgn     = RG_GPR;
                    d.gpr_idx = slot - GPR_FIRST;
                end
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rfd_addr_former.sv
module rfd_addr_former
    import rfd_pkg::*;
(
    input  logic          bank,
    input  logic [OW-1:0] opnd,
    input  logic [AW-1:0] ptr,
    output logic [AW-1:0] ea
);

    always_comb begin
        ea = form_addr(bank, opnd, ptr);
    end

endmodule

// File: rtl/rfd_core_regs.sv
module rfd_core_regs
    import rfd_pkg::*;
#(
    parameter int               N        = NCORE,
    parameter logic [N-1:0]     RST_MASK = CORE_RST_MASK
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  core_e                 sel,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic [N-1:0][DW-1:0]  q
);

    for (genvar i = 0; i < N; i++) begin : g_reg
        logic hit;
        assign hit = we && (int'(sel) == i);
        if (RST_MASK[i]) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst)      q[i] <= '0;
                else if (hit) q[i] <= wdata;
            end
        end else begin : g_norst
            always_ff @(posedge clk) begin
                if (hit) q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (int'(sel) == i) rdata = q[i];
        end
    end

endmodule

// File: rtl/rfd_gpr_ram.sv
module rfd_gpr_ram
    import rfd_pkg::*;
#(
    parameter int DEPTH = GPR_DEPTH,
    parameter int IW    = OW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];
    logic          in_range;

    assign in_range = int'(idx) < DEPTH;

    always_ff @(posedge clk) begin
        if (we && in_range) mem[idx] <= wdata;
    end

    always_comb begin
        rdata = in_range ? mem[idx] : '0;
    end

endmodule

// File: rtl/rfd_bank_decoder.sv
module rfd_bank_decoder
    import rfd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  opnd,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        per_sel,
    output logic [7:0]  per_addr,
    output logic        per_we,
    output logic [7:0]  per_wdata,
    input  logic [7:0]  per_rdata,
    output logic [7:0]  pc_low,
    output logic [7:0]  pc_latch,
    output logic [7:0]  status_q,
    output logic [7:0]  ptr_q,
    output logic [7:0]  irq_ctrl_q
);

    logic [AW-1:0]             eff_addr;
    dec_t                      dec;
    logic [NCORE-1:0][DW-1:0]  core_q;
    logic [DW-1:0]             core_rd;
    logic [DW-1:0]             gpr_rd;
    logic                      core_we;
    logic                      gpr_we;

    rfd_addr_former u_former (
        .bank (core_q[CR_STAT][BANK_BIT]),
        .opnd (opnd),
        .ptr  (core_q[CR_PTR]),
        .ea   (eff_addr)
    );

    always_comb begin
        dec = decode_slot(eff_addr[OW-1:0]);
    end

    assign core_we = wr_en && (dec.rgn == RG_CORE);
    assign gpr_we  = wr_en && (dec.rgn == RG_GPR);

    rfd_core_regs #(
        .N        (NCORE),
        .RST_MASK (CORE_RST_MASK)
    ) u_core (
        .clk   (clk),
        .rst   (rst),
        .we    (core_we),
        .sel   (dec.core),
        .wdata (wr_data),
        .rdata (core_rd),
        .q     (core_q)
    );

    rfd_gpr_ram #(
        .DEPTH (GPR_DEPTH),
        .IW    (OW)
    ) u_gpr (
        .clk   (clk),
        .we    (gpr_we),
        .idx   (dec.gpr_idx),
        .wdata (wr_data),
        .rdata (gpr_rd)
    );

    always_comb begin
        case (dec.rgn)
            RG_CORE:   rd_data = core_rd;
            RG_GPR:    rd_data = gpr_rd;
            RG_PERIPH: rd_data = per_rdata;
            default:   rd_data = '0;
        endcase
    end

    assign per_sel    = (dec.rgn == RG_PERIPH);
    assign per_addr   = eff_addr;
    assign per_we     = wr_en && per_sel;
    assign per_wdata  = wr_data;

    assign pc_low     = core_q[CR_PCL];
    assign pc_latch   = core_q[CR_PCLATH];
    assign status_q   = core_q[CR_STAT];
    assign ptr_q      = core_q[CR_PTR];
    assign irq_ctrl_q = core_q[CR_INTCON];

endmodule

// File: rtl/rfd_bank_decoder_chk.sv
module rfd_bank_decoder_chk
    import rfd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [6:0] opnd,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic       per_sel,
    input logic [7:0] per_addr,
    input logic       per_we,
    input logic [7:0] per_rdata,
    input logic [7:0] status_q,
    input logic [7:0] ptr_q,
    input logic [7:0] irq_ctrl_q,
    input logic [7:0] eff_addr
);

    logic is_hole;
    assign is_hole = (eff_addr[6:0] == 7'h07) || (eff_addr[6:0] >= 7'h50);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (status_q == 8'h00 && ptr_q == 8'h00 && irq_ctrl_q == 8'h00));

    // R2
    direct_form_chk: assert property (@(posedge clk) disable iff (rst)
        (opnd != 7'h00) |-> (eff_addr == {status_q[BANK_BIT], opnd}));

    // R3
    indirect_form_chk: assert property (@(posedge clk) disable iff (rst)
        (opnd == 7'h00) |-> (eff_addr == ptr_q));

    // R7
    hole_zero_chk: assert property (@(posedge clk) disable iff (rst)
        is_hole |-> (rd_data == 8'h00 && !per_sel && !per_we));

    // R8
    null_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (opnd == 7'h00 && ptr_q[6:0] == 7'h00) |-> (rd_data == 8'h00 && !per_we));

    // R9
    periph_route_chk: assert property (@(posedge clk) disable iff (rst)
        per_sel |-> (rd_data == per_rdata && per_addr == eff_addr));

    // R9
    periph_we_chk: assert property (@(posedge clk) disable iff (rst)
        per_we |-> (wr_en && per_sel));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(status_q) && $stable(ptr_q) && $stable(irq_ctrl_q)));

endmodule

bind rfd_bank_decoder rfd_bank_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .opnd       (opnd),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .per_sel    (per_sel),
    .per_addr   (per_addr),
    .per_we     (per_we),
    .per_rdata  (per_rdata),
    .status_q   (status_q),
    .ptr_q      (ptr_q),
    .irq_ctrl_q (irq_ctrl_q),
    .eff_addr   (eff_addr)
);

// File: tb/rfd_bank_decoder_test.sv
`timescale 1ns/1ps
module rfd_bank_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] opnd = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       per_sel;
    logic [7:0] per_addr;
    logic       per_we;
    logic [7:0] per_wdata;
    logic [7:0] per_rdata = 8'hA5;
    logic [7:0] pc_low, pc_latch, status_q, ptr_q, irq_ctrl_q;

    int n_tests = 0;
    int n_fail  = 0;
    logic last_pwe;
    logic last_psel;

    always #4 clk = ~clk;

    rfd_bank_decoder uut (
        .clk(clk), .rst(rst), .opnd(opnd), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .per_sel(per_sel), .per_addr(per_addr), .per_we(per_we),
        .per_wdata(per_wdata), .per_rdata(per_rdata), .pc_low(pc_low),
        .pc_latch(pc_latch), .status_q(status_q), .ptr_q(ptr_q),
        .irq_ctrl_q(irq_ctrl_q)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        opnd = a; wr_data = d; wr_en = 1'b1;
        #1;
        last_pwe  = per_we;
        last_psel = per_sel;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] a, output logic [7:0] v);
        @(negedge clk);
        opnd = a; wr_en = 1'b0;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_read(7'h03, v); chk("R1 status", v, 8'h00);
        do_read(7'h04, v); chk("R1 pointer", v, 8'h00);
        do_read(7'h0B, v); chk("R1 intctl", v, 8'h00);
        do_read(7'h05, v); chk("R1 bank0 after reset", per_addr, 8'h05);
    endtask

    task automatic t_direct_bank();
        logic [7:0] v;
        do_write(7'h03, 8'h20);
        chk("R2 bank bit set", status_q, 8'h20);
        per_rdata = 8'h3E;
        do_read(7'h05, v);
        chk("R2 bank1 addr", per_addr, 8'h85);
        chk("R9 per_sel", {7'h0, per_sel}, 8'h01);
        chk("R9 per rdata", v, 8'h3E);
        do_read(7'h09, v);
        chk("R9 bank1 slot 89", per_addr, 8'h89);
        do_write(7'h08, 8'h6B);
        chk("R9 per_we on write", {7'h0, last_pwe}, 8'h01);
        do_write(7'h03, 8'h00);
        chk("R2 bank cleared via 83h", status_q, 8'h00);
        do_read(7'h06, v);
        chk("R2 bank0 addr", per_addr, 8'h06);
    endtask

    task automatic t_core_mirror();
        logic [7:0] v;
        do_write(7'h0A, 8'h3C);
        do_write(7'h02, 8'h77);
        chk("R5 pc_low port", pc_low, 8'h77);
        do_write(7'h03, 8'h20);
        do_read(7'h0A, v); chk("R5 latch mirror", v, 8'h3C);
        do_read(7'h02, v); chk("R5 pcl mirror", v, 8'h77);
        do_write(7'h0B, 8'h81);
        chk("R5 intctl via 8Bh", irq_ctrl_q, 8'h81);
        do_write(7'h03, 8'h00);
        do_read(7'h0B, v); chk("R5 intctl bank0", v, 8'h81);
        chk("R5 latch port", pc_latch, 8'h3C);
    endtask

    task automatic t_gpr_mirror();
        logic [7:0] v;
        do_write(7'h4F, 8'h11);
        do_write(7'h0C, 8'h22);
        do_write(7'h03, 8'h20);
        do_read(7'h4F, v); chk("R6 CFh alias", v, 8'h11);
        do_read(7'h0C, v); chk("R6 8Ch alias", v, 8'h22);
        do_write(7'h20, 8'h33);
        do_write(7'h03, 8'h00);
        do_read(7'h20, v); chk("R6 A0h to 20h", v, 8'h33);
    endtask

    task automatic t_holes();
        logic [7:0] v;
        do_read(7'h07, v); chk("R7 07h", v, 8'h00);
        do_read(7'h50, v); chk("R7 50h", v, 8'h00);
        do_read(7'h7F, v); chk("R7 7Fh", v, 8'h00);
        do_write(7'h50, 8'hFF);
        chk("R7 no per_we", {7'h0, last_pwe}, 8'h00);
        do_write(7'h07, 8'hEE);
        chk("R7 no per_sel", {7'h0, last_psel}, 8'h00);
        do_read(7'h4F, v); chk("R7 4Fh intact", v, 8'h11);
        do_read(7'h0C, v); chk("R7 0Ch intact", v, 8'h22);
        do_write(7'h03, 8'h20);
        do_read(7'h07, v); chk("R7 87h", v, 8'h00);
        do_read(7'h50, v); chk("R7 D0h", v, 8'h00);
        do_read(7'h7F, v); chk("R7 FFh", v, 8'h00);
        do_write(7'h7F, 8'h99);
        do_write(7'h03, 8'h00);
        do_read(7'h4F, v); chk("R7 after FFh write", v, 8'h11);
        chk("R7 status intact", status_q, 8'h00);
    endtask

    task automatic t_indirect();
        logic [7:0] v;
        do_write(7'h04, 8'hCF);
        do_read(7'h00, v); chk("R3 read via ptr", v, 8'h11);
        do_write(7'h00, 8'h5A);
        do_read(7'h4F, v); chk("R3 write via ptr", v, 8'h5A);
        do_write(7'h04, 8'h85);
        per_rdata = 8'hC3;
        do_read(7'h00, v);
        chk("R4 ptr reaches bank1", per_addr, 8'h85);
        chk("R4 bank bit still 0", status_q, 8'h00);
        chk("R4 per data", v, 8'hC3);
        do_write(7'h04, 8'h0A);
        do_read(7'h00, v); chk("R3 ptr to core", v, 8'h3C);
    endtask

    task automatic t_null();
        logic [7:0] v;
        do_write(7'h04, 8'h00);
        do_read(7'h00, v); chk("R8 ptr 00 read", v, 8'h00);
        do_write(7'h00, 8'hAA);
        chk("R8 ptr 00 no per_we", {7'h0, last_pwe}, 8'h00);
        chk("R8 ptr unchanged", ptr_q, 8'h00);
        chk("R8 status unchanged", status_q, 8'h00);
        do_write(7'h04, 8'h80);
        do_read(7'h00, v); chk("R8 ptr 80 read", v, 8'h00);
        do_write(7'h00, 8'hAA);
        chk("R8 ptr 80 kept", ptr_q, 8'h80);
        do_read(7'h0B, v); chk("R8 intctl intact", v, 8'h81);
        do_read(7'h4F, v); chk("R8 ram intact", v, 8'h5A);
    endtask

    task automatic t_timing();
        @(negedge clk);
        opnd = 7'h30; wr_data = 8'h01; wr_en = 1'b1;
        @(negedge clk);
        wr_data = 8'h02;
        #1;
        chk("R10 old value before edge", rd_data, 8'h01);
        @(posedge clk);
        #1;
        chk("R10 new value after edge", rd_data, 8'h02);
        @(negedge clk);
        wr_en = 1'b0;
        opnd = 7'h31;
        #1;
        opnd = 7'h30;
        #1;
        chk("R10 combinational read", rd_data, 8'h02);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct_bank();
        t_core_mirror();
        t_gpr_mirror();
        t_holes();
        t_indirect();
        t_null();
        t_timing();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule